// File: doc/BRIEF.md
# Core Clock Wake-Up Timer and Divider

This block sits between an oscillator clock and the processor core. On a start event, either release of reset or a wake request, it holds the core clock enable low. It releases the enable only after a stabilization count has run out. The length of that count depends on the selected oscillator source. Crystal sources use a long base count. The internal RC, watchdog and external-clock sources use a short base count. Both lengths add a fixed settling interval, given as a parameter in oscillator cycles.

Once released, the oscillator clock is divided by a programmable ratio. The result is a one-cycle clock-enable pulse that the core uses as its clock qualifier. Software may rewrite the 8-bit divider value at any time. A new value takes effect only at the end of the divide period in progress, so the core never sees a shortened period. The block also holds a low-power-select bit that software can write. Every reset clears this bit.

Top module: `clk_wake_div`

## Requirements
- R1: After reset the ready flag, the clock enable and the low-power-select bit are 0, and the divider value is 0.
- R2: With source code 0, 1 or 2 (the crystal sources), `ready_o` rises exactly XTAL_CYC+SETTLE_CYC oscillator edges after the start event.
- R3: With any source code from 3 to 7, `ready_o` rises exactly OTHER_CYC+SETTLE_CYC edges after the start event.
- R4: A wake request clears `ready_o` on the next edge and restarts the stabilization count. This also applies when a count is already running. Once set, `ready_o` stays high until the next wake request or reset.
- R5: `clk_en_o` is 0 whenever `ready_o` is 0.
- R6: `clk_en_o` is high in the first cycle in which `ready_o` is high.
- R7: With divider value N ≥ 1, enable pulses are spaced exactly 2·N cycles apart. With N = 0, the enable is high in every ready cycle.
- R8: A divider write takes effect only after the terminal count of the period in progress. The current period completes at its old length, and the new spacing applies from the next pulse.
- R9: `lp_sel_o` changes only on a write through `lp_we_i`, and a wake request leaves it unchanged.
- R10: The divider value is retained across wake requests; only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Wake request; restarts the stabilization count |
| src_sel_i | input | 3 | Oscillator source code (0-2 crystal, 3-7 other) |
| div_we_i | input | 1 | Divider value write strobe |
| div_wdata_i | input | 8 | Divider value N (ratio 2·N, 0 = undivided) |
| lp_we_i | input | 1 | Low-power-select write strobe |
| lp_wdata_i | input | 1 | Low-power-select write data |
| clk_en_o | output | 1 | Core clock enable pulse |
| ready_o | output | 1 | Clock released after stabilization |
| lp_sel_o | output | 1 | Low-power-select bit |

## Verification
The hardest case to reach is a divider write that lands in the middle of a divide period. To observe it, the enable pulses must be counted both before and after the terminal count. The bench first programs a ratio of 8 and locks onto an enable pulse. It then advances a known number of cycles and writes a ratio of 2. It checks that the remainder of the old period runs to completion before the short spacing appears. The bench also restarts a running stabilization count with a second wake request, to show that the count is restarted and not merely extended.

// File: rtl/clkw_pkg.sv
package clkw_pkg;
  localparam int unsigned SRC_W = 3;
  localparam int unsigned XTAL_MAX_CODE = 2;

  function automatic logic src_is_xtal(input logic [SRC_W-1:0] code);
    return (code <= SRC_W'(XTAL_MAX_CODE));
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/clkw_wake_timer.sv
module clkw_wake_timer
  import clkw_pkg::*;
#(
  parameter int unsigned XTAL_CYC   = 992,
  parameter int unsigned OTHER_CYC  = 224,
  parameter int unsigned SETTLE_CYC = 16,
  localparam int unsigned LIM_MAX   = max_u(XTAL_CYC, OTHER_CYC) + SETTLE_CYC,
  localparam int unsigned CW        = $clog2(LIM_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_i,
  input  logic [SRC_W-1:0] src_sel_i,
  output logic             ready_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;

  always_comb begin
    lim_m1 = src_is_xtal(src_sel_i) ? CW'(XTAL_CYC + SETTLE_CYC - 1)
                                    : CW'(OTHER_CYC + SETTLE_CYC - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (wake_i) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      if (cnt_q == lim_m1) ready_o <= 1'b1;
      else                 cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R4
  wake_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !ready_o);

  // R4
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !wake_i) |=> ready_o);

endmodule

// File: rtl/clkw_divider.sv
module clkw_divider #(
  parameter  int unsigned NW = 8,
  localparam int unsigned PW = NW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic          we_i,
  input  logic [NW-1:0] wdata_i,
  output logic          en_o
);

  logic [NW-1:0] pend_q, act_q, nxt_n;
  logic [PW-1:0] dcnt_q, per_m1;
  logic          term;

  always_comb begin
    per_m1 = (act_q == '0) ? '0 : ({act_q, 1'b0} - 1'b1);
    term   = (dcnt_q == per_m1);
    nxt_n  = we_i ? wdata_i : pend_q;
    en_o   = ready_i && (dcnt_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
      dcnt_q <= '0;
    end else begin
      if (we_i) pend_q <= wdata_i;
      // ratio switches only at a period boundary
      if (!ready_i || term) begin
        dcnt_q <= '0;
        act_q  <= nxt_n;
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end

  // R7
  no_short_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && act_q != '0) |=> !en_o);

  // R7
  back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && $past(en_o) && $past(ready_i)) |-> ($past(act_q) == '0));

  // R8
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !term) |=> $stable(act_q));

endmodule

// File: rtl/clk_wake_div.sv
module clk_wake_div
  import clkw_pkg::*;
#(
  parameter int unsigned XTAL_CYC   = 992,
  parameter int unsigned OTHER_CYC  = 224,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned DIV_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wake_i,
  input  logic [2:0]       src_sel_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             lp_we_i,
  input  logic             lp_wdata_i,
  output logic             clk_en_o,
  output logic             ready_o,
  output logic             lp_sel_o
);

  logic ready;

  clkw_wake_timer #(
    .XTAL_CYC  (XTAL_CYC),
    .OTHER_CYC (OTHER_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wake_i   (wake_i),
    .src_sel_i(src_sel_i),
    .ready_o  (ready)
  );

  clkw_divider #(.NW(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_i(ready),
    .we_i   (div_we_i),
    .wdata_i(div_wdata_i),
    .en_o   (clk_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lp_sel_o <= 1'b0;
    else if (lp_we_i) lp_sel_o <= lp_wdata_i;
  end

  assign ready_o = ready;

  // R6
  first_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> clk_en_o);

  // R9
  lp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_we_i |=> $stable(lp_sel_o));

  // R5
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> !clk_en_o);

endmodule

// File: tb/clk_wake_div_test.sv
module clk_wake_div_test;
  localparam int XT = 992, OT = 224, ST = 16;
  localparam int LIM_X = XT + ST;
  localparam int LIM_O = OT + ST;

  logic clk = 0, rst_n = 0, wake = 0, div_we = 0, lp_we = 0, lp_wd = 0;
  logic [2:0] src = 3'd3;
  logic [7:0] div_wd = 0;
  logic clk_en, ready, lp_sel;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_wake_div #(.XTAL_CYC(XT), .OTHER_CYC(OT), .SETTLE_CYC(ST)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .src_sel_i(src),
    .div_we_i(div_we), .div_wdata_i(div_wd), .lp_we_i(lp_we), .lp_wdata_i(lp_wd),
    .clk_en_o(clk_en), .ready_o(ready), .lp_sel_o(lp_sel));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_wake();
    wake = 1; step(); wake = 0;
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin step(); g++; end while (!clk_en && g < 1200);
  endtask

  task automatic sync_en();
    int k = 0;
    while (!clk_en && k < 1200) begin step(); k++; end
  endtask

  task automatic test_reset_release();
    chk("R1 ready", ready, 0);
    chk("R1 en", clk_en, 0);
    chk("R1 lp", lp_sel, 0);
    rst_n = 1;
    repeat (LIM_O - 1) step();
    chk("R3 reset start early", ready, 0);
    step();
    chk("R3 reset start ready", ready, 1);
    chk("R6 first en", clk_en, 1);
  endtask

  task automatic test_delay(input logic [2:0] s, input int lim, input string req);
    src = s;
    do_wake();
    chk({req, " wake clears"}, ready, 0);
    chk("R5 no en", clk_en, 0);
    repeat (lim - 1) step();
    chk({req, " early"}, ready, 0);
    step();
    chk({req, " ready"}, ready, 1);
    chk("R6 en at release", clk_en, 1);
  endtask

  task automatic test_restart();
    int g;
    src = 3'd4;
    do_wake();
    repeat (100) step();
    chk("R4 counting", ready, 0);
    do_wake();
    repeat (LIM_O - 1) step();
    chk("R4 restart early", ready, 0);
    step();
    chk("R4 restart ready", ready, 1);
  endtask

  task automatic test_div(input int n);
    int g, exp;
    exp = (n == 0) ? 1 : 2 * n;
    div_wd = 8'(n); div_we = 1; step(); div_we = 0;
    sync_en(); gap(g);
    gap(g); chk("R7 gap a", g, exp);
    gap(g); chk("R7 gap b", g, exp);
  endtask

  task automatic test_switch();
    int g;
    test_div(4);
    step(); step();
    div_wd = 8'd1; div_we = 1; step(); div_we = 0;
    gap(g); chk("R8 old period completes", g, 5);
    gap(g); chk("R8 new period", g, 2);
    gap(g); chk("R8 new period again", g, 2);
  endtask

  task automatic test_keep_div();
    int g;
    test_div(2);
    src = 3'd7;
    do_wake();
    repeat (LIM_O) step();
    chk("R10 ready", ready, 1);
    chk("R10 en at release", clk_en, 1);
    gap(g); chk("R10 ratio kept", g, 4);
  endtask

  task automatic test_lp();
    lp_wd = 1; lp_we = 1; step(); lp_we = 0;
    chk("R9 lp set", lp_sel, 1);
    do_wake();
    chk("R9 lp after wake", lp_sel, 1);
    step();
    chk("R9 lp hold", lp_sel, 1);
  endtask

  task automatic test_final_reset();
    int g;
    rst_n = 0; #1;
    chk("R1 lp cleared", lp_sel, 0);
    chk("R1 ready cleared", ready, 0);
    @(negedge clk); src = 3'd3; rst_n = 1;
    repeat (LIM_O) step();
    chk("R1 ready after reset", ready, 1);
    gap(g); chk("R1 divider cleared", g, 1);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    test_reset_release();
    test_delay(3'd0, LIM_X, "R2 code0");
    test_delay(3'd2, LIM_X, "R2 code2");
    test_delay(3'd5, LIM_O, "R3 code5");
    test_restart();
    test_div(0);
    test_div(3);
    test_switch();
    test_keep_div();
    test_lp();
    test_final_reset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule